// File: doc/BRIEF.md
# Dual-Pixel Serial Word Framer

This block sits between a parallel camera port and a serial link transmitter. It samples an 11-bit pixel bus, together with horizontal sync, vertical sync and a forward control bit, on either edge of the pixel clock. It joins each two accepted samples into one 24-bit link word: the pair fills bits 21:0, the control bit goes in bit 22 and an even parity bit in bit 23. Words leave at half the pixel rate, each marked by a one-cycle strobe.

When sync encoding is on, the sync lines are not carried in pixel bits. Pixels are accepted only while both sync inputs are high. Every sync transition instead queues a dedicated event word that holds a one-hot event code and no pixel data. If a transition finds a lone pixel waiting for its partner, that pixel is sent first, padded with zeros. When encoding is off, every sample is a pixel and the sync lines only feed the timing checker. The checker watches both sync inputs for pulses that are too short and for periods with an odd cycle count, and it keeps a sticky error flag.

Top module: `dual_pixel_framer`

## Requirements
- R1: With `edge_sel_i` = 1 the block uses the inputs as they stand at the falling pixel-clock edge. With `edge_sel_i` = 0 it uses them as they stand at the rising edge.
- R2: Two consecutive accepted pixels form one word. The earlier pixel goes in bits 10:0 and the later one in bits 21:11.
- R3: Bit 22 of every word is the control input taken with the sample that completes the word. Bit 23 makes the total count of ones in bits 23:0 even.
- R4: With `sync_enc_i` = 1 a sample is a pixel only when both HS and VS are high. Samples taken while either is low produce no pixel word.
- R5: With `sync_enc_i` = 1 each sync transition produces an event word. Bits 21:4 are zero and bits 3:0 carry a code: bit 0 for HS rising, bit 1 for HS falling, bit 2 for VS rising, bit 3 for VS falling. When both lines change in the same cycle, the HS word comes before the VS word, and any pixel word of that cycle comes after both.
- R6: If a sync transition arrives while one pixel waits for its partner, that pixel is emitted first. It sits in bits 10:0 with bits 21:11 zero, ahead of the event words.
- R7: With `sync_enc_i` = 0 every sample is a pixel, whatever the sync levels, and no event words are produced.
- R8: `word_vld_o` is high for single cycles only, never on two cycles in a row. Queued words come out in the order they were produced, one per strobe, at the first free strobe slot. `word_o` holds its value between strobes.
- R9: A low pulse shorter than 5 samples or a high pulse shorter than 2 samples, on HS or VS, sets `timing_err_o`, which then stays set until reset. The partial run that starts at reset is not judged.
- R10: A high run plus the low run that follows it, on HS or VS, must total an even number of samples. An odd total sets `timing_err_o`.
- R11: During reset, `word_o` is zero and both `word_vld_o` and `timing_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| edge_sel_i | input | 1 | Capture edge: 1 falling, 0 rising |
| sync_enc_i | input | 1 | 1 sends sync as event words and gates pixels by sync |
| pix_i | input | 11 | Pixel sample |
| hs_i | input | 1 | Horizontal sync, high during active line |
| vs_i | input | 1 | Vertical sync, high during active frame |
| fwd_ctl_i | input | 1 | Forward control-channel bit |
| word_o | output | 24 | Link word: parity, control, pixel pair or event code |
| word_vld_o | output | 1 | One-cycle strobe marking a new word |
| timing_err_o | output | 1 | Sticky sync timing violation flag |

## Verification
A stale waiting pixel or a lost sync history shows up at the ports as a pair made of the wrong samples, as a missing zero-padded flush word, or as an event word with the wrong code bit. Each of these appears on the first strobe slot after the cycle that goes wrong, which is two to four clocks after the faulty sample. A fault in the queue breaks word order or strobe spacing on the next strobe. A miscounted pulse length changes `timing_err_o` on the clock right after the sync edge that closes the run. The bench models all of this from the sampled input stream and compares every output on every cycle.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
  // at most flush + HS event + VS event + pixel pair per sample
  localparam int PUSH_MAX = 4;
  localparam int PUSH_W   = $clog2(PUSH_MAX + 1);
  localparam int PUSH_IW  = $clog2(PUSH_MAX);
  // event code bit positions inside a sync-event word
  localparam int EV_HS_RISE = 0;
  localparam int EV_HS_FALL = 1;
  localparam int EV_VS_RISE = 2;
  localparam int EV_VS_FALL = 3;
endpackage

// File: rtl/dpf_capture.sv
module dpf_capture #(
  parameter int PIX_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_sel_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             hs_i,
  input  logic             vs_i,
  input  logic             ctl_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             hs_o,
  output logic             vs_o,
  output logic             ctl_o
);
  localparam int SW = PIX_W + 3;

  logic [SW-1:0] in_w, rise_q, fall_q, fall_rq;

  assign in_w = {ctl_i, vs_i, hs_i, pix_i};

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rise_q <= '0;
    else         rise_q <= in_w;

  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) fall_q <= '0;
    else         fall_q <= in_w;

  // retime falling capture so both paths have equal latency
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) fall_rq <= '0;
    else         fall_rq <= fall_q;

  assign {ctl_o, vs_o, hs_o, pix_o} = edge_sel_i ? fall_rq : rise_q;
endmodule

// File: rtl/dpf_sync_check.sv
module dpf_sync_check #(
  parameter int RUN_W    = 16,
  parameter int MIN_LOW  = 5,
  parameter int MIN_HIGH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic err_o
);
  logic             lvl_q, seen_q, hi_vld_q, err_q;
  logic [RUN_W-1:0] run_q, hi_len_q;
  logic [RUN_W:0]   period_w;
  logic             edge_w, short_w, odd_w;

  assign edge_w   = lvl_i ^ lvl_q;
  assign short_w  = seen_q && (lvl_q ? (run_q < RUN_W'(MIN_HIGH)) : (run_q < RUN_W'(MIN_LOW)));
  assign period_w = {1'b0, hi_len_q} + {1'b0, run_q};
  assign odd_w    = !lvl_q && hi_vld_q && period_w[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q    <= 1'b0;
      seen_q   <= 1'b0;
      hi_vld_q <= 1'b0;
      hi_len_q <= '0;
      run_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
      if (edge_w) begin
        err_q  <= err_q | short_w | odd_w;
        if (lvl_q) begin
          hi_len_q <= run_q;
          hi_vld_q <= seen_q;
        end
        seen_q <= 1'b1;
        run_q  <= RUN_W'(1);
      end else if (!(&run_q)) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign err_o = err_q;

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: rtl/dpf_packer.sv
module dpf_packer
  import dpf_pkg::*;
#(
  parameter int PIX_W = 11
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   enc_i,
  input  logic [PIX_W-1:0]                       pix_i,
  input  logic                                   hs_i,
  input  logic                                   vs_i,
  input  logic                                   ctl_i,
  output logic [PUSH_W-1:0]                      push_n_o,
  output logic [PUSH_MAX-1:0][2*PIX_W+1:0]       push_w_o
);
  localparam int BODY_W = 2 * PIX_W;
  localparam int WORD_W = BODY_W + 2;

  logic             half_vld_q, half_vld_d, hs_q, vs_q;
  logic [PIX_W-1:0] half_q, half_d;
  logic             active, hs_r, hs_f, vs_r, vs_f, flush;
  logic [BODY_W-1:0] hs_body, vs_body;
  logic [PUSH_IW-1:0] idx;

  function automatic logic [WORD_W-1:0] seal(input logic [BODY_W-1:0] body, input logic c);
    return {^{c, body}, c, body};
  endfunction

  always_comb begin
    active = enc_i ? (hs_i & vs_i) : 1'b1;
    hs_r   = enc_i &  hs_i & ~hs_q;
    hs_f   = enc_i & ~hs_i &  hs_q;
    vs_r   = enc_i &  vs_i & ~vs_q;
    vs_f   = enc_i & ~vs_i &  vs_q;
    flush  = (hs_r | hs_f | vs_r | vs_f) & half_vld_q;

    hs_body = '0;
    hs_body[EV_HS_RISE] = hs_r;
    hs_body[EV_HS_FALL] = hs_f;
    vs_body = '0;
    vs_body[EV_VS_RISE] = vs_r;
    vs_body[EV_VS_FALL] = vs_f;

    push_w_o   = '0;
    push_n_o   = '0;
    idx        = '0;
    half_vld_d = half_vld_q & ~flush;
    half_d     = half_q;

    if (flush) begin
      push_w_o[idx] = seal(BODY_W'(half_q), ctl_i);
      idx = idx + 1'b1;
      push_n_o = push_n_o + 1'b1;
    end
    if (hs_r | hs_f) begin
      push_w_o[idx] = seal(hs_body, ctl_i);
      idx = idx + 1'b1;
      push_n_o = push_n_o + 1'b1;
    end
    if (vs_r | vs_f) begin
      push_w_o[idx] = seal(vs_body, ctl_i);
      idx = idx + 1'b1;
      push_n_o = push_n_o + 1'b1;
    end
    if (active) begin
      if (half_vld_d) begin
        push_w_o[idx] = seal({pix_i, half_q}, ctl_i);
        push_n_o   = push_n_o + 1'b1;
        half_vld_d = 1'b0;
      end else begin
        half_vld_d = 1'b1;
        half_d     = pix_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_vld_q <= 1'b0;
      half_q     <= '0;
      hs_q       <= 1'b0;
      vs_q       <= 1'b0;
    end else begin
      half_vld_q <= half_vld_d;
      half_q     <= half_d;
      hs_q       <= hs_i;
      vs_q       <= vs_i;
    end
  end
endmodule

// File: rtl/dpf_word_fifo.sv
module dpf_word_fifo
  import dpf_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int DEPTH  = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [PUSH_W-1:0]                push_n_i,
  input  logic [PUSH_MAX-1:0][WORD_W-1:0]  push_w_i,
  output logic [WORD_W-1:0]                word_o,
  output logic                             vld_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][WORD_W-1:0] mem_q, mem_d;
  logic [CW-1:0]                cnt_q, cnt_d;
  logic                         tog_q, pop;
  int                           base, fill;

  assign pop = tog_q && (cnt_q != '0);

  // pop shifts toward slot 0; pushes land after the surviving entries
  always_comb begin
    mem_d = mem_q;
    base  = int'(cnt_q);
    if (pop) begin
      for (int j = 0; j < DEPTH - 1; j++) mem_d[j] = mem_q[j+1];
      mem_d[DEPTH-1] = '0;
      base = base - 1;
    end
    for (int j = 0; j < DEPTH; j++)
      for (int i = 0; i < PUSH_MAX; i++)
        if (i < int'(push_n_i) && j == base + i) mem_d[j] = push_w_i[i];
    fill = base + int'(push_n_i);
    if (fill > DEPTH) fill = DEPTH;
    cnt_d = CW'(fill);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q  <= '0;
      cnt_q  <= '0;
      tog_q  <= 1'b0;
      word_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      mem_q <= mem_d;
      cnt_q <= cnt_d;
      tog_q <= ~tog_q;
      vld_o <= pop;
      if (pop) word_o <= mem_q[0];
    end
  end

  assert_strobe_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);

  assert_fill_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/dual_pixel_framer.sv
module dual_pixel_framer
  import dpf_pkg::*;
#(
  parameter int PIX_W      = 11,
  parameter int FIFO_DEPTH = 8,
  parameter int RUN_W      = 16,
  parameter int MIN_LOW    = 5,
  parameter int MIN_HIGH   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               edge_sel_i,
  input  logic               sync_enc_i,
  input  logic [PIX_W-1:0]   pix_i,
  input  logic               hs_i,
  input  logic               vs_i,
  input  logic               fwd_ctl_i,
  output logic [2*PIX_W+1:0] word_o,
  output logic               word_vld_o,
  output logic               timing_err_o
);
  localparam int WORD_W = 2 * PIX_W + 2;

  logic [PIX_W-1:0]                pix_s;
  logic                            hs_s, vs_s, ctl_s;
  logic [PUSH_W-1:0]               push_n;
  logic [PUSH_MAX-1:0][WORD_W-1:0] push_w;
  logic [1:0]                      lvl, err;

  dpf_capture #(.PIX_W(PIX_W)) u_cap (
    .clk_i, .rst_ni, .edge_sel_i,
    .pix_i, .hs_i, .vs_i, .ctl_i(fwd_ctl_i),
    .pix_o(pix_s), .hs_o(hs_s), .vs_o(vs_s), .ctl_o(ctl_s)
  );

  dpf_packer #(.PIX_W(PIX_W)) u_pack (
    .clk_i, .rst_ni, .enc_i(sync_enc_i),
    .pix_i(pix_s), .hs_i(hs_s), .vs_i(vs_s), .ctl_i(ctl_s),
    .push_n_o(push_n), .push_w_o(push_w)
  );

  dpf_word_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_n_i(push_n), .push_w_i(push_w),
    .word_o, .vld_o(word_vld_o)
  );

  assign lvl = {vs_s, hs_s};

  for (genvar g = 0; g < 2; g++) begin : g_chk
    dpf_sync_check #(.RUN_W(RUN_W), .MIN_LOW(MIN_LOW), .MIN_HIGH(MIN_HIGH)) u_chk (
      .clk_i, .rst_ni, .lvl_i(lvl[g]), .err_o(err[g])
    );
  end

  assign timing_err_o = |err;

  assert_word_parity_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> ~^word_o);
endmodule

// File: tb/dual_pixel_framer_test.sv
`timescale 1ns/1ps
module dual_pixel_framer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        edge_sel_i = 1'b0;
  logic        sync_enc_i = 1'b0;
  logic [10:0] pix_i = '0;
  logic        hs_i = 1'b0;
  logic        vs_i = 1'b0;
  logic        fwd_ctl_i = 1'b0;
  logic [23:0] word_o;
  logic        word_vld_o;
  logic        timing_err_o;

  dual_pixel_framer uut (
    .clk_i, .rst_ni, .edge_sel_i, .sync_enc_i, .pix_i, .hs_i, .vs_i,
    .fwd_ctl_i, .word_o, .word_vld_o, .timing_err_o
  );

  always #2 clk_i = ~clk_i;

  typedef struct { logic [10:0] pix; logic hs; logic vs; logic ctl; } smp_t;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // reference model state
  smp_t        sq[$];
  logic [23:0] wq[$];
  string       tq[$];
  int          edge_n, pcnt, seen_vld, exp_vld_n;
  logic [23:0] exp_word;
  logic        exp_vld, exp_err;
  string       exp_tag, pix_tag, err_tag;
  logic        m_half_v, m_phs, m_pvs;
  logic [10:0] m_half;
  int          c_lvl[2], c_seen[2], c_hiv[2], c_run[2], c_hilen[2];
  bit          skew;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] seal(input logic [21:0] body, input logic c);
    logic p;
    p = 1'b0;
    for (int i = 0; i < 22; i++) p = p ^ body[i];
    p = p ^ c;
    return {p, c, body};
  endfunction

  task automatic push_w(input logic [23:0] w, input string t);
    if (wq.size() < 8) begin
      wq.push_back(w);
      tq.push_back(t);
    end
  endtask

  task automatic model_sync(input int k, input logic x);
    if (int'(x) != c_lvl[k]) begin
      if (c_seen[k] != 0) begin
        if (c_lvl[k] == 1 && c_run[k] < 2) exp_err = 1'b1;
        if (c_lvl[k] == 0 && c_run[k] < 5) exp_err = 1'b1;
      end
      if (c_lvl[k] == 0 && c_hiv[k] != 0 && ((c_hilen[k] + c_run[k]) % 2) == 1) exp_err = 1'b1;
      if (c_lvl[k] == 1) begin
        c_hilen[k] = c_run[k];
        c_hiv[k]   = c_seen[k];
      end
      c_seen[k] = 1;
      c_run[k]  = 1;
    end else begin
      c_run[k]++;
    end
    c_lvl[k] = int'(x);
  endtask

  task automatic model_edge();
    smp_t s;
    bit act, hr, hf, vr, vf, fl;
    // output slot on odd edges since reset
    if ((edge_n % 2) == 1 && wq.size() > 0) begin
      exp_word = wq.pop_front();
      exp_tag  = tq.pop_front();
      exp_vld  = 1'b1;
      exp_vld_n++;
    end else begin
      exp_vld = 1'b0;
    end
    s   = sq.pop_front();
    act = sync_enc_i ? (s.hs && s.vs) : 1'b1;
    hr  = sync_enc_i && s.hs && !m_phs;
    hf  = sync_enc_i && !s.hs && m_phs;
    vr  = sync_enc_i && s.vs && !m_pvs;
    vf  = sync_enc_i && !s.vs && m_pvs;
    fl  = (hr || hf || vr || vf) && m_half_v;
    if (fl) begin
      push_w(seal({11'd0, m_half}, s.ctl), "R6");
      m_half_v = 1'b0;
    end
    if (hr || hf) push_w(seal({18'd0, 2'b00, hf, hr}, s.ctl), "R5");
    if (vr || vf) push_w(seal({18'd0, vf, vr, 2'b00}, s.ctl), "R5");
    if (act) begin
      if (m_half_v) begin
        push_w(seal({s.pix, m_half}, s.ctl), pix_tag);
        m_half_v = 1'b0;
      end else begin
        m_half_v = 1'b1;
        m_half   = s.pix;
      end
    end
    m_phs = s.hs;
    m_pvs = s.vs;
    model_sync(0, s.hs);
    model_sync(1, s.vs);
    edge_n++;
  endtask

  task automatic compare();
    if (word_vld_o) seen_vld++;
    check(word_vld_o == exp_vld, "R8", "strobe", 32'(word_vld_o), 32'(exp_vld));
    check(word_o == exp_word, exp_tag, "word", 32'(word_o), 32'(exp_word));
    if (word_vld_o) check(~^word_o, "R3", "parity", 32'(word_o), 32'(exp_word));
    check(timing_err_o == exp_err, err_tag, "timing_err", 32'(timing_err_o), 32'(exp_err));
  endtask

  task automatic cycle(input logic h, input logic v);
    smp_t s;
    logic [10:0] pa, pb;
    logic c;
    @(posedge clk_i);
    #1;
    model_edge();
    compare();
    pa = 11'((pcnt * 181 + 37) & 32'h7ff);
    c  = 1'((pcnt >> 1) & 1);
    pcnt++;
    pix_i = pa; hs_i = h; vs_i = v; fwd_ctl_i = c;
    #2;
    pb = skew ? (pa ^ 11'h7ff) : pa;
    pix_i = pb;
    s.pix = edge_sel_i ? pa : pb;
    s.hs = h; s.vs = v; s.ctl = c;
    sq.push_back(s);
  endtask

  task automatic run(input int n, input logic h, input logic v);
    for (int i = 0; i < n; i++) cycle(h, v);
  endtask

  task automatic start(input logic sel, input logic enc, input bit sk,
                       input string pt, input string et);
    smp_t z;
    @(posedge clk_i);
    #1;
    rst_ni = 1'b0;
    edge_sel_i = sel; sync_enc_i = enc; skew = sk;
    pix_i = '0; hs_i = 1'b0; vs_i = 1'b0; fwd_ctl_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    check(word_o == 24'd0, "R11", "reset word", 32'(word_o), 0);
    check(!word_vld_o, "R11", "reset strobe", 32'(word_vld_o), 0);
    check(!timing_err_o, "R11", "reset err", 32'(timing_err_o), 0);
    z.pix = '0; z.hs = 1'b0; z.vs = 1'b0; z.ctl = 1'b0;
    sq.delete(); wq.delete(); tq.delete();
    sq.push_back(z); sq.push_back(z);
    edge_n = 0; seen_vld = 0; exp_vld_n = 0;
    exp_word = '0; exp_vld = 1'b0; exp_err = 1'b0; exp_tag = "R11";
    pix_tag = pt; err_tag = et;
    m_half_v = 1'b0; m_half = '0; m_phs = 1'b0; m_pvs = 1'b0;
    for (int k = 0; k < 2; k++) begin
      c_lvl[k] = 0; c_seen[k] = 0; c_hiv[k] = 0; c_run[k] = 0; c_hilen[k] = 0;
    end
    rst_ni = 1'b1;
  endtask

  task automatic finish_phase(input string cnt_tag);
    run(12, 1'b0, 1'b0);
    check(seen_vld == exp_vld_n, cnt_tag, "word count", 32'(seen_vld), 32'(exp_vld_n));
  endtask

  // frame: odd-length lines flush a lone pixel; last line even; periods even
  task automatic frame();
    run(8, 1'b0, 1'b0);
    run(6, 1'b0, 1'b1);
    for (int l = 0; l < 2; l++) begin
      run(7, 1'b1, 1'b1);
      run(5, 1'b0, 1'b1);
    end
    run(8, 1'b1, 1'b1);
    run(8, 1'b0, 1'b0);
    run(6, 1'b0, 1'b1);
    run(10, 1'b0, 1'b0);
  endtask

  initial begin
    pcnt = 0;
    // R2 R4 R5 R6: rising-edge capture, sync encoding on
    start(1'b0, 1'b1, 1'b1, "R2", "R10");
    frame();
    finish_phase("R4");
    // R1: falling-edge capture
    start(1'b1, 1'b1, 1'b1, "R1", "R10");
    frame();
    finish_phase("R4");
    // R7: encoding off, sync only checked
    start(1'b0, 1'b0, 1'b0, "R7", "R10");
    frame();
    finish_phase("R7");
    // R9: short low pulse
    start(1'b0, 1'b1, 1'b0, "R2", "R9");
    run(8, 1'b0, 1'b0); run(6, 1'b0, 1'b1); run(4, 1'b1, 1'b1);
    run(3, 1'b0, 1'b1); run(4, 1'b1, 1'b1); run(10, 1'b0, 1'b0);
    check(timing_err_o == 1'b1, "R9", "short low flagged", 32'(timing_err_o), 1);
    finish_phase("R8");
    // R9: short high pulse
    start(1'b0, 1'b1, 1'b0, "R2", "R9");
    run(8, 1'b0, 1'b0); run(6, 1'b0, 1'b1); run(4, 1'b1, 1'b1);
    run(6, 1'b0, 1'b1); run(1, 1'b1, 1'b1); run(7, 1'b0, 1'b1);
    run(10, 1'b0, 1'b0);
    check(timing_err_o == 1'b1, "R9", "short high flagged", 32'(timing_err_o), 1);
    finish_phase("R8");
    // R10: odd period
    start(1'b1, 1'b1, 1'b0, "R2", "R10");
    run(8, 1'b0, 1'b0); run(6, 1'b0, 1'b1); run(4, 1'b1, 1'b1);
    run(5, 1'b0, 1'b1); run(4, 1'b1, 1'b1); run(10, 1'b0, 1'b0);
    check(timing_err_o == 1'b1, "R10", "odd period flagged", 32'(timing_err_o), 1);
    finish_phase("R8");
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule